// File: doc/BRIEF.md
# Auto-MDIX Link Resolution Controller

This block brings up one copper Ethernet port without software. After a start pulse it sets the pair-swap select to straight (MDI) pairing. It then polls the PHY's basic status register. Before each poll it waits a timed interval. Whenever the link bit is still clear, it swaps the pairing between MDI and crossover (MDIX) and tries again.

Once link is seen, the controller reads a fixed chain of PHY registers. From them it works out line speed, duplex and whether both ends agreed on pause flow control. It then publishes a single status word with a one-cycle strobe. PHY registers are reached through a simple request/acknowledge read channel. Serialising that channel onto the management wire is done by a separate block.

The wait interval is a prescaled tick count. The tick length and the tick count are both parameters, so the same RTL serves millisecond-scale waits in silicon and very short waits in a small test configuration.

Top module: `amdix_link_ctrl`

## Requirements
- R1: A start pulse seen while the controller is idle forces `xover_mdix` to 0 (MDI) and clears `done`, `fail` and the resolved flags. A start pulse seen while a run is in progress has no effect on that run.
- R2: Every link poll waits WAIT_TICKS*TICK_CYCLES clock cycles and then issues a read of PHY address 1. The gap counts from the edge that accepted start or the previous failed poll. `rd_req` rises on the edge WAIT_TICKS*TICK_CYCLES+1 cycles after that edge.
- R3: A poll response with bit 2 clear inverts `xover_mdix` and starts the next attempt. A response with bit 2 set ends polling, and `xover_mdix` keeps its value from then on.
- R4: After MAX_TRIES polls without link, `fail` is set, `done` stays 0 and no status strobe is produced. `xover_mdix` is then left inverted once per failed poll.
- R5: After link, PHY address 1 is read a second time. If bit 5 of that value is clear, the run ends with `done` set and no status strobe.
- R6: When bit 5 is set, PHY address 31 is read and bits 4:2 are decoded. Code 1 means 10 Mb/s half duplex, 5 means 10 full, 2 means 100 half and 6 means 100 full. Any other code leaves both the speed and the duplex flags clear. Status word bit 1 is the 100 Mb/s flag and bit 2 is the full-duplex flag.
- R7: The pause flag (status word bit 3) is set only when four bits are all 1: bit 3 of the second status read, address 6 bit 0, address 4 bit 10 and address 5 bit 10. The reads run in the order 6, 4, 5. A read is only issued while every earlier check has passed, and the chain stops at the first check that fails.
- R8: A successful run produces exactly one `stat_valid` pulse, one cycle long. It comes on the same edge that sets `done`, and status word bit 0 (link) is 1 in it.
- R9: At most one read is outstanding. `rd_req` stays high with `rd_addr` unchanged until a cycle in which `rd_ack` is high, and `rd_data` is taken in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a bring-up run (used only when idle) |
| rd_req | output | 1 | PHY register read request |
| rd_addr | output | 5 | PHY register address of the request |
| rd_ack | input | 1 | Read response valid; completes the request |
| rd_data | input | 16 | Read response data |
| xover_mdix | output | 1 | Pair select: 0 = MDI, 1 = MDIX |
| stat_valid | output | 1 | One-cycle strobe for `stat_word` |
| stat_word | output | 4 | {pause, full duplex, 100 Mb/s, link} |
| done | output | 1 | Run ended with link (sticky until next start) |
| fail | output | 1 | Run ended without link (sticky until next start) |

## Verification
A wrong attempt counter or a wrong interval shows up quickly at the ports. It appears as a poll gap that differs from WAIT_TICKS*TICK_CYCLES+1 cycles, as one poll too many or too few before `fail`, or as a crossover level that does not match the parity of the failed polls. A fault in the resolution chain appears within the same run. It shows up as an extra or missing read of 6, 4 or 5 in the request sequence, or as a status word whose speed, duplex or pause bits disagree with the decode table. Sweeping every register-31 code against every combination of the four pause inputs, with both pairing polarities, several link delays and several response latencies, covers each branch.

// File: rtl/amdix_pkg.sv
// Shared constants and types for the auto-MDIX link resolution controller.
// Assumes a 16-bit PHY register data path and 5-bit register addresses.
package amdix_pkg;

    localparam int PHY_ADDR_W = 5;
    localparam int PHY_DATA_W = 16;

    // PHY register addresses walked by the sequencer
    localparam logic [PHY_ADDR_W-1:0] REG_BSTAT  = 5'd1;
    localparam logic [PHY_ADDR_W-1:0] REG_ADV    = 5'd4;
    localparam logic [PHY_ADDR_W-1:0] REG_LPABIL = 5'd5;
    localparam logic [PHY_ADDR_W-1:0] REG_ANEXP  = 5'd6;
    localparam logic [PHY_ADDR_W-1:0] REG_SPCTL  = 5'd31;

    // Bit positions inside the read values
    localparam int BIT_LINK    = 2;
    localparam int BIT_ANABLE  = 3;
    localparam int BIT_ANDONE  = 5;
    localparam int BIT_LPNEG   = 0;
    localparam int BIT_PAUSE   = 10;
    localparam int MODE_LSB    = 2;

    // Speed/duplex codes from register 31 bits 4:2
    localparam logic [2:0] MODE_10_HALF  = 3'd1;
    localparam logic [2:0] MODE_100_HALF = 3'd2;
    localparam logic [2:0] MODE_10_FULL  = 3'd5;
    localparam logic [2:0] MODE_100_FULL = 3'd6;

    // Status word layout
    localparam int STAT_W      = 4;
    localparam int ST_LINK     = 0;
    localparam int ST_FAST     = 1;
    localparam int ST_FULL     = 2;
    localparam int ST_PAUSE    = 3;

    typedef enum logic [3:0] {
        SQ_IDLE,
        SQ_WAIT,
        SQ_POLL,
        SQ_RECHECK,
        SQ_MODE,
        SQ_LPNEG,
        SQ_LOCPAUSE,
        SQ_LPPAUSE,
        SQ_PUBLISH
    } seq_state_t;

endpackage

// File: rtl/amdix_wait_timer.sv
// Interval timer: a prescaler divides the clock into ticks of TICK_CYCLES
// cycles and a second counter counts WAIT_TICKS ticks. An arm pulse restarts
// both; expired is high from the cycle the count completes until re-armed
// or the timer stops itself one cycle later.
// Assumes TICK_CYCLES >= 1 and WAIT_TICKS >= 1.
module amdix_wait_timer #(
    parameter int TICK_CYCLES = 50000,
    parameter int WAIT_TICKS  = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    output logic expired
);
    localparam int CYC_W  = $clog2(TICK_CYCLES + 1);
    localparam int TICK_W = $clog2(WAIT_TICKS + 1);

    logic              running;
    logic [CYC_W-1:0]  cyc_cnt;
    logic [TICK_W-1:0] tick_cnt;

    assign expired = running && (tick_cnt == TICK_W'(WAIT_TICKS));

    // Prescaler and tick counter; arm reloads, expiry stops the timer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running  <= 1'b0;
            cyc_cnt  <= '0;
            tick_cnt <= '0;
        end else if (arm) begin
            running  <= 1'b1;
            cyc_cnt  <= '0;
            tick_cnt <= '0;
        end else if (expired) begin
            running  <= 1'b0;
        end else if (running) begin
            if (cyc_cnt == CYC_W'(TICK_CYCLES - 1)) begin
                cyc_cnt  <= '0;
                tick_cnt <= tick_cnt + 1'b1;
            end else begin
                cyc_cnt  <= cyc_cnt + 1'b1;
            end
        end
    end

    assert_tick_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (tick_cnt <= TICK_W'(WAIT_TICKS)));

    assert_expiry_ends_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && !arm) |=> !running);

endmodule

// File: rtl/amdix_mode_decode.sv
// Decodes the 3-bit speed/duplex code reported by the PHY into a 100 Mb/s
// flag and a full-duplex flag. Codes outside the four defined values give
// neither flag. Purely combinational.
module amdix_mode_decode
    import amdix_pkg::*;
(
    input  logic [2:0] mode_code,
    output logic       fast,
    output logic       full
);
    // Table lookup of the four defined codes
    always_comb begin
        fast = 1'b0;
        full = 1'b0;
        case (mode_code)
            MODE_10_HALF:  begin fast = 1'b0; full = 1'b0; end
            MODE_10_FULL:  begin fast = 1'b0; full = 1'b1; end
            MODE_100_HALF: begin fast = 1'b1; full = 1'b0; end
            MODE_100_FULL: begin fast = 1'b1; full = 1'b1; end
            default:       begin fast = 1'b0; full = 1'b0; end
        endcase
    end

    always_comb begin
        assert_undef_clear_R6: assert (!(fast || full) ||
            mode_code == MODE_10_FULL || mode_code == MODE_100_HALF ||
            mode_code == MODE_100_FULL);
    end

endmodule

// File: rtl/amdix_link_ctrl.sv
// Auto-MDIX link resolution controller (top). On start it selects MDI
// pairing and polls PHY register 1 after each timed wait, swapping the pair
// select after every poll without link, for at most MAX_TRIES polls. After
// link it rereads register 1, then reads 31, 6, 4, 5 as needed to resolve
// speed, duplex and pause, and publishes one status word.
// Assumes one read outstanding at a time; a request is held until rd_ack.
module amdix_link_ctrl
    import amdix_pkg::*;
#(
    parameter int TICK_CYCLES = 50000,
    parameter int WAIT_TICKS  = 2000,
    parameter int MAX_TRIES   = 100
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    output logic                  rd_req,
    output logic [PHY_ADDR_W-1:0] rd_addr,
    input  logic                  rd_ack,
    input  logic [PHY_DATA_W-1:0] rd_data,
    output logic                  xover_mdix,
    output logic                  stat_valid,
    output logic [STAT_W-1:0]     stat_word,
    output logic                  done,
    output logic                  fail
);
    localparam int TRY_W = $clog2(MAX_TRIES + 1);

    seq_state_t       state;
    logic [TRY_W-1:0] tries;
    logic             an_able;
    logic             res_fast;
    logic             res_full;
    logic             res_pause;
    logic             tmr_arm;
    logic             tmr_expired;
    logic             dec_fast;
    logic             dec_full;
    logic             accept;
    logic             launch;
    logic             last_try;
    logic             unused_bits;

    assign unused_bits = ^{rd_data[15:11], rd_data[9:6], rd_data[1]};

    assign launch   = (state == SQ_IDLE) && start;
    assign accept   = rd_req && rd_ack;
    assign last_try = (tries == TRY_W'(MAX_TRIES - 1));
    assign tmr_arm  = launch ||
                      ((state == SQ_POLL) && accept && !rd_data[BIT_LINK] && !last_try);

    amdix_wait_timer #(
        .TICK_CYCLES (TICK_CYCLES),
        .WAIT_TICKS  (WAIT_TICKS)
    ) i_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm     (tmr_arm),
        .expired (tmr_expired)
    );

    amdix_mode_decode i_decode (
        .mode_code (rd_data[MODE_LSB +: 3]),
        .fast      (dec_fast),
        .full      (dec_full)
    );

    // Request and address are a pure function of the sequencer state
    always_comb begin
        rd_req  = 1'b1;
        rd_addr = REG_BSTAT;
        case (state)
            SQ_POLL, SQ_RECHECK: rd_addr = REG_BSTAT;
            SQ_MODE:             rd_addr = REG_SPCTL;
            SQ_LPNEG:            rd_addr = REG_ANEXP;
            SQ_LOCPAUSE:         rd_addr = REG_ADV;
            SQ_LPPAUSE:          rd_addr = REG_LPABIL;
            default:             rd_req  = 1'b0;
        endcase
    end

    // Sequencer: link wait loop, resolution chain and result publication
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= SQ_IDLE;
            tries      <= '0;
            an_able    <= 1'b0;
            res_fast   <= 1'b0;
            res_full   <= 1'b0;
            res_pause  <= 1'b0;
            xover_mdix <= 1'b0;
            stat_valid <= 1'b0;
            stat_word  <= '0;
            done       <= 1'b0;
            fail       <= 1'b0;
        end else begin
            stat_valid <= 1'b0;
            case (state)
                SQ_IDLE: if (start) begin
                    xover_mdix <= 1'b0;
                    tries      <= '0;
                    an_able    <= 1'b0;
                    res_fast   <= 1'b0;
                    res_full   <= 1'b0;
                    res_pause  <= 1'b0;
                    done       <= 1'b0;
                    fail       <= 1'b0;
                    state      <= SQ_WAIT;
                end
                SQ_WAIT: if (tmr_expired) state <= SQ_POLL;
                SQ_POLL: if (accept) begin
                    if (rd_data[BIT_LINK]) begin
                        state <= SQ_RECHECK;
                    end else begin
                        xover_mdix <= ~xover_mdix;
                        tries      <= tries + 1'b1;
                        if (last_try) begin
                            fail  <= 1'b1;
                            state <= SQ_IDLE;
                        end else begin
                            state <= SQ_WAIT;
                        end
                    end
                end
                SQ_RECHECK: if (accept) begin
                    if (rd_data[BIT_ANDONE]) begin
                        an_able <= rd_data[BIT_ANABLE];
                        state   <= SQ_MODE;
                    end else begin
                        done  <= 1'b1;
                        state <= SQ_IDLE;
                    end
                end
                SQ_MODE: if (accept) begin
                    res_fast <= dec_fast;
                    res_full <= dec_full;
                    state    <= an_able ? SQ_LPNEG : SQ_PUBLISH;
                end
                SQ_LPNEG: if (accept)
                    state <= rd_data[BIT_LPNEG] ? SQ_LOCPAUSE : SQ_PUBLISH;
                SQ_LOCPAUSE: if (accept)
                    state <= rd_data[BIT_PAUSE] ? SQ_LPPAUSE : SQ_PUBLISH;
                SQ_LPPAUSE: if (accept) begin
                    res_pause <= rd_data[BIT_PAUSE];
                    state     <= SQ_PUBLISH;
                end
                SQ_PUBLISH: begin
                    stat_word[ST_LINK]  <= 1'b1;
                    stat_word[ST_FAST]  <= res_fast;
                    stat_word[ST_FULL]  <= res_full;
                    stat_word[ST_PAUSE] <= res_pause;
                    stat_valid          <= 1'b1;
                    done                <= 1'b1;
                    state               <= SQ_IDLE;
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    assert_mdi_on_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> (!xover_mdix && !done && !fail));

    assert_pair_hold_in_wait_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_WAIT) |=> $stable(xover_mdix));

    assert_no_status_on_fail_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> !stat_valid);

    assert_done_fail_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fail));

    assert_link_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stat_valid |-> (stat_word[ST_LINK] && done));

    assert_one_shot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stat_valid |=> !stat_valid);

    assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr)));

endmodule

// File: tb/test_amdix_link_ctrl.sv
// Self-checking bench: a PHY responder model answers reads with a variable
// latency, and a sweep of link delay, pair polarity, speed code and pause
// inputs is checked against outcomes computed from the requirements.
module test_amdix_link_ctrl;
    localparam int CLK_PERIOD  = 10;
    localparam int TICK_CYCLES = 3;
    localparam int WAIT_TICKS  = 2;
    localparam int MAX_TRIES   = 6;
    localparam int GAP         = WAIT_TICKS * TICK_CYCLES + 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        rd_req;
    logic [4:0]  rd_addr;
    logic        rd_ack = 1'b0;
    logic [15:0] rd_data = '0;
    logic        xover_mdix;
    logic        stat_valid;
    logic [3:0]  stat_word;
    logic        done;
    logic        fail;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    // PHY model settings for the current case
    bit         m_need, m_b5, m_b3, m_r6, m_r4, m_r5;
    int         m_dly, m_lat;
    logic [2:0] m_code;
    bit         linked_seen;
    int         poll_idx;
    int         req_in_run;
    int         got_n;
    logic [4:0] got_addr [0:31];
    int         stat_cnt;
    logic [3:0] stat_cap;

    amdix_link_ctrl #(
        .TICK_CYCLES (TICK_CYCLES),
        .WAIT_TICKS  (WAIT_TICKS),
        .MAX_TRIES   (MAX_TRIES)
    ) i_amdix_link_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .rd_req     (rd_req),
        .rd_addr    (rd_addr),
        .rd_ack     (rd_ack),
        .rd_data    (rd_data),
        .xover_mdix (xover_mdix),
        .stat_valid (stat_valid),
        .stat_word  (stat_word),
        .done       (done),
        .fail       (fail)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [15:0] phy_value(input logic [4:0] a);
        logic [15:0] v;
        v = 16'h0000;
        case (a)
            5'd1: begin
                if (!linked_seen) begin
                    v = 16'h0028;
                    if (poll_idx >= m_dly && xover_mdix == m_need) begin
                        linked_seen = 1'b1;
                        v[2] = 1'b1;
                    end
                    poll_idx++;
                end else begin
                    v = 16'h0004;
                    v[5] = m_b5;
                    v[3] = m_b3;
                end
            end
            5'd31: begin v = 16'hFFE3; v[4:2] = m_code; end
            5'd6:  v = 16'hFFFE | 16'(m_r6);
            5'd4:  v = m_r4 ? 16'hFFFF : 16'hFBFF;
            5'd5:  v = m_r5 ? 16'h0400 : 16'hFBFF;
            default: v = 16'h0000;
        endcase
        return v;
    endfunction

    // Responder: one request at a time, ack after m_lat cycles; checks R2 gaps and R9 holding
    initial begin
        bit         busy;
        int         lat_cnt;
        int         low_run;
        logic [4:0] held;
        busy = 1'b0; lat_cnt = 0; low_run = 0; held = '0;
        forever begin
            @(negedge clk);
            if (rd_ack) begin
                rd_ack = 1'b0;
                busy = 1'b0;
            end
            if (!rd_req) begin
                low_run++;
                if (busy) begin
                    chk(1'b0, "R9 request dropped before ack", 0, 1);
                    busy = 1'b0;
                end
            end else begin
                if (!busy) begin
                    busy = 1'b1;
                    held = rd_addr;
                    lat_cnt = 0;
                    if (req_in_run > 0 && low_run > 0)
                        chk(low_run == GAP, "R2 poll gap", low_run, GAP);
                    req_in_run++;
                    low_run = 0;
                end else begin
                    chk(rd_addr == held, "R9 address held", int'(rd_addr), int'(held));
                end
                if (lat_cnt >= m_lat) begin
                    rd_data = phy_value(rd_addr);
                    rd_ack = 1'b1;
                    if (got_n < 32) got_addr[got_n] = rd_addr;
                    got_n++;
                end else begin
                    lat_cnt++;
                end
            end
        end
    end

    // Status monitor
    initial begin
        forever begin
            @(negedge clk);
            if (stat_valid) begin
                stat_cnt++;
                stat_cap = stat_word;
            end
        end
    end

    task automatic run_case(input bit need, input int dly, input bit b5, input bit b3,
                            input logic [2:0] code, input bit r6, input bit r4,
                            input bit r5, input int lat, input bit poke);
        int         attempt;
        bit         linked;
        int         exp_n;
        logic [4:0] exp_addr [0:31];
        logic [3:0] exp_word;
        bit         seq_ok;
        m_need = need; m_dly = dly; m_b5 = b5; m_b3 = b3; m_code = code;
        m_r6 = r6; m_r4 = r4; m_r5 = r5; m_lat = lat;
        linked_seen = 1'b0; poll_idx = 0; req_in_run = 0; got_n = 0; stat_cnt = 0;
        // Expected sequence from the requirements
        linked = 1'b0; attempt = 0;
        for (int a = 0; a < MAX_TRIES; a++) begin
            if (!linked && a >= dly && (a % 2) == int'(need)) begin
                linked = 1'b1; attempt = a;
            end
        end
        exp_n = 0;
        for (int a = 0; a < (linked ? attempt + 1 : MAX_TRIES); a++) begin
            exp_addr[exp_n] = 5'd1; exp_n++;
        end
        if (linked) begin
            exp_addr[exp_n] = 5'd1; exp_n++;
            if (b5) begin
                exp_addr[exp_n] = 5'd31; exp_n++;
                if (b3) begin
                    exp_addr[exp_n] = 5'd6; exp_n++;
                    if (r6) begin
                        exp_addr[exp_n] = 5'd4; exp_n++;
                        if (r4) begin exp_addr[exp_n] = 5'd5; exp_n++; end
                    end
                end
            end
        end
        exp_word[0] = 1'b1;
        exp_word[1] = (code == 3'd2) || (code == 3'd6);
        exp_word[2] = (code == 3'd5) || (code == 3'd6);
        exp_word[3] = b3 && r6 && r4 && r5;

        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk(!done && !fail && !xover_mdix, "R1 start clears flags and selects MDI",
            int'({done, fail, xover_mdix}), 0);
        if (poke) begin
            repeat (3) @(negedge clk);
            start = 1'b1;
            @(negedge clk); start = 1'b0;
        end
        while (!(done || fail)) @(negedge clk);
        repeat (3) @(negedge clk);

        chk(done == (linked ? 1'b1 : 1'b0), linked ? "R5 done after link" : "R4 no done on fail",
            int'(done), int'(linked));
        chk(fail == (linked ? 1'b0 : 1'b1), "R4 fail flag", int'(fail), int'(!linked));
        chk(stat_cnt == ((linked && b5) ? 1 : 0), "R8 status strobe count",
            stat_cnt, (linked && b5) ? 1 : 0);
        if (linked && b5) begin
            chk(stat_cap[1:0] == exp_word[1:0], "R6 speed and link bits",
                int'(stat_cap), int'(exp_word));
            chk(stat_cap[2] == exp_word[2], "R6 duplex bit", int'(stat_cap), int'(exp_word));
            chk(stat_cap[3] == exp_word[3], "R7 pause bit", int'(stat_cap), int'(exp_word));
        end
        chk(xover_mdix == (linked ? need : bit'(MAX_TRIES % 2)), "R3 final pair select",
            int'(xover_mdix), linked ? int'(need) : (MAX_TRIES % 2));
        chk(got_n == exp_n, linked ? "R7 read count" : "R4 poll count", got_n, exp_n);
        seq_ok = (got_n == exp_n);
        for (int k = 0; k < exp_n && k < 32; k++)
            if (seq_ok && got_addr[k] != exp_addr[k]) seq_ok = 1'b0;
        chk(seq_ok, "R7 read order", got_n, exp_n);
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!rd_req && !xover_mdix && !stat_valid && !done && !fail, "R1 reset state",
            int'({rd_req, xover_mdix, stat_valid, done, fail}), 0);

        // Full sweep of mode codes and pause chain inputs, both polarities
        for (int code = 0; code < 8; code++) begin
            for (int p = 0; p < 16; p++) begin
                run_case(bit'(p[0] ^ code[0]), code % 3, 1'b1, bit'(p[0]), 3'(code),
                         bit'(p[1]), bit'(p[2]), bit'(p[3]), (code + p) % 3, 1'b0);
            end
        end
        // Link never found, both target polarities (R4)
        run_case(1'b0, MAX_TRIES, 1'b1, 1'b1, 3'd6, 1'b1, 1'b1, 1'b1, 0, 1'b0);
        run_case(1'b1, MAX_TRIES, 1'b1, 1'b1, 3'd6, 1'b1, 1'b1, 1'b1, 2, 1'b0);
        // Link on the very last attempt
        run_case(1'b1, MAX_TRIES - 1, 1'b1, 1'b0, 3'd2, 1'b0, 1'b0, 1'b0, 1, 1'b0);
        // Resolution not complete: done without status (R5)
        run_case(1'b0, 0, 1'b0, 1'b1, 3'd6, 1'b1, 1'b1, 1'b1, 0, 1'b0);
        run_case(1'b1, 2, 1'b0, 1'b0, 3'd5, 1'b1, 1'b1, 1'b1, 2, 1'b0);
        // Start pulse during a run is ignored (R1)
        run_case(1'b1, 1, 1'b1, 1'b1, 3'd6, 1'b1, 1'b1, 1'b1, 1, 1'b1);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule